// File: doc/BRIEF.md
# Boot PROM overlay with auto-disable

This block fronts a small RAM window at the bottom of the processor memory map. Right after reset, the lowest part of that window is covered by a short read-only boot program, so the processor fetches its first instructions from the overlay. The boot program is computed from a fixed rule rather than loaded. Writes always land in the RAM beneath, so boot code can fill the area under the overlay while still running from it.

The first read at an address with the trigger bit set (bit 5, the first bit above the overlay range) turns the overlay off. It stays off until the next reset, and the whole window then behaves as plain RAM. A configuration input, standing for a board switch, can hide the overlay without changing its armed state. Read data is registered and valid one clock after the read strobe.

Top module: `boot_ovl_top`

## Requirements
- R1: After reset `rdata_o` is 0x00 and the overlay is armed, so a read of address 0x00 returns PROM byte 0.
- R2: While the overlay is visible, a read at address i below 32 returns the PROM byte ((i*29) mod 256) XOR 0xA5.
- R3: A write always stores `wdata_i` into RAM at `addr_i`, including at addresses 0..31 while the overlay is visible. The written byte does not show on reads there while the overlay stays visible.
- R4: A read at an address of 32 or higher returns RAM contents, even while the overlay is armed. If bit 5 of the address is clear, the overlay stays armed.
- R5: A read at an address with bit 5 set disarms the overlay and returns RAM data. After it, reads at 0..31 return the RAM contents.
- R6: Once disarmed, the overlay stays off for any later sequence of reads, writes and configuration values until reset. Reset arms it again and leaves the RAM contents unchanged.
- R7: With `cfg_en_i` low, every read returns RAM. A trigger read still disarms the overlay. Raising `cfg_en_i` again shows the PROM only if the overlay is still armed.
- R8: `rdata_o` updates on the clock edge that samples `rd_i` high and holds its value while `rd_i` is low.
- R9: When a read and a write hit the same RAM address in one cycle, the read returns the old contents and the next read returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; arms the overlay |
| cfg_en_i | input | 1 | Board-switch enable; low hides the overlay |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 8 | Window address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
A wrongly kept or lost enable flag shows on the very next read below 32. It returns a PROM byte where the RAM byte written earlier was expected, or the reverse. A trigger read that returns PROM data, or that fails to disarm, differs at the port one clock after that read. A broken write path under the overlay stays hidden until the overlay is disarmed, so the bench fills that area with random data before the trigger read and compares all of it afterwards.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;
  parameter int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // boot image rule: (i*29) xor 0xA5
  function automatic byte_t prom_byte(input int unsigned idx);
    logic [31:0] v;
    v = idx * 32'd29;
    return byte_t'(v) ^ byte_t'(8'hA5);
  endfunction
endpackage

// File: rtl/boot_ovl_ram.sv
module boot_ovl_ram
  import boot_ovl_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  byte_t         wdata_i,
  output byte_t         rdata_o
);
  byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/boot_ovl_rom.sv
module boot_ovl_rom
  import boot_ovl_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic [AW-1:0] idx_i,
  output byte_t         data_o
);
  byte_t tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    assign tbl[g] = prom_byte(g);
  end

  assign data_o = tbl[idx_i];
endmodule

// File: rtl/boot_ovl_ctl.sv
module boot_ovl_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic trig_i,
  input  logic cfg_en_i,
  output logic visible_o
);
  logic armed_q;

  // one-way: only reset re-arms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              armed_q <= 1'b1;
    else if (rd_i && trig_i)  armed_q <= 1'b0;
  end

  assign visible_o = armed_q & cfg_en_i;
endmodule

// File: rtl/boot_ovl_top.sv
module boot_ovl_top
  import boot_ovl_pkg::*;
#(
  parameter int unsigned RAM_DEPTH = 256,
  parameter int unsigned ROM_DEPTH = 32,
  localparam int unsigned AW = $clog2(RAM_DEPTH),
  localparam int unsigned RW = $clog2(ROM_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_en_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  byte_t ram_rd, rom_rd, rdata_q;
  logic  visible, in_rom;

  boot_ovl_ram #(.DEPTH(RAM_DEPTH)) i_ram (
    .clk_i   (clk_i),
    .we_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (ram_rd)
  );

  boot_ovl_rom #(.DEPTH(ROM_DEPTH)) i_rom (
    .idx_i  (addr_i[RW-1:0]),
    .data_o (rom_rd)
  );

  boot_ovl_ctl i_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd_i),
    .trig_i    (addr_i[RW]),
    .cfg_en_i  (cfg_en_i),
    .visible_o (visible)
  );

  assign in_rom = (addr_i[AW-1:RW] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_i)  rdata_q <= (visible && in_rom) ? rom_rd : ram_rd;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/boot_ovl_chk.sv
module boot_ovl_chk
  import boot_ovl_pkg::*;
#(
  parameter int unsigned RAM_DEPTH = 256,
  parameter int unsigned ROM_DEPTH = 32,
  localparam int unsigned AW = $clog2(RAM_DEPTH),
  localparam int unsigned RW = $clog2(ROM_DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_en_i,
  input logic          rd_i,
  input logic [AW-1:0] addr_i,
  input byte_t         rdata_o,
  input logic          armed_i
);
  AST_TRIGGER_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[RW]) |=> !armed_i); // R5

  AST_STAYS_DISARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> !armed_i); // R6

  AST_PROM_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && armed_i && cfg_en_i && (int'(addr_i) < ROM_DEPTH))
    |=> (rdata_o == prom_byte(int'($past(addr_i))))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R8
endmodule

bind boot_ovl_top boot_ovl_chk #(.RAM_DEPTH(RAM_DEPTH), .ROM_DEPTH(ROM_DEPTH)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_en_i (cfg_en_i),
  .rd_i     (rd_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .armed_i  (i_ctl.armed_q)
);

// File: tb/test_boot_ovl_top.sv
module test_boot_ovl_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b1;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;

  logic [7:0] mdl_mem [256];
  logic       mdl_ok  [256];
  logic       mdl_armed = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_ovl_top i_boot_ovl_top (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [7:0] exp_prom(input int i);
    return 8'(((i * 29) % 256) ^ 8'hA5);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // one bus cycle; compares rdata when a check is possible
  task automatic op(input string req, input logic r, input logic w, input logic [7:0] a,
                    input logic [7:0] d, input logic c);
    logic [7:0] e;
    logic       known;
    @(negedge clk);
    rd = r; wr = w; addr = a; wdata = d; cfg_en = c;
    known = 1'b0; e = '0;
    if (r) begin
      if (mdl_armed && c && a < 8'd32) begin e = exp_prom(int'(a)); known = 1'b1; end
      else begin e = mdl_mem[a]; known = mdl_ok[a]; end
    end
    if (w) begin mdl_mem[a] = d; mdl_ok[a] = 1'b1; end
    if (r && a[5]) mdl_armed = 1'b0;
    @(posedge clk); #1;
    rd = 1'b0; wr = 1'b0;
    if (r && known) check(req, rdata, e);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; mdl_armed = 1'b1;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd7321));
    for (int i = 0; i < 256; i++) mdl_ok[i] = 1'b0;
    #(CLK_PERIOD * 2);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1 reset rdata", rdata, 8'h00);
    op("R1 first fetch", 1, 0, 8'h00, 8'h00, 1);

    for (int i = 0; i < 32; i++) op("R2 prom image", 1, 0, 8'(i), 8'h00, 1);

    for (int i = 0; i < 256; i++) op("R3 fill", 0, 1, 8'(i), 8'($urandom), 1);
    op("R3 hidden under prom", 1, 0, 8'h05, 8'h00, 1);

    for (int i = 8'h40; i < 8'h60; i++) op("R4 ram above prom", 1, 0, 8'(i), 8'h00, 1);
    op("R4 still armed", 1, 0, 8'h03, 8'h00, 1);

    op("R7 cfg off shows ram", 1, 0, 8'h07, 8'h00, 0);
    op("R7 cfg back on shows prom", 1, 0, 8'h07, 8'h00, 1);

    held = rdata;
    @(negedge clk); addr = 8'h99; cfg_en = 1'b0;
    @(posedge clk); #1;
    check("R8 hold while idle", rdata, held);

    op("R9 read old", 1, 1, 8'h90, 8'h3C, 1);
    op("R9 read new", 1, 0, 8'h90, 8'h00, 1);

    for (int n = 0; n < 300; n++) begin
      logic [7:0] a;
      a = 8'($urandom) & 8'hDF;
      op("R4 random armed", ($urandom % 2) == 0, ($urandom % 3) == 0, a, 8'($urandom),
         ($urandom % 4) != 0);
    end

    op("R5 trigger read returns ram", 1, 0, 8'h25, 8'h00, 1);
    for (int i = 0; i < 32; i++) op("R5 ram visible after trigger", 1, 0, 8'(i), 8'h00, 1);

    for (int n = 0; n < 400; n++)
      op("R6 stays off", ($urandom % 2) == 0, ($urandom % 3) == 0, 8'($urandom), 8'($urandom),
         ($urandom % 2) == 0);
    for (int i = 0; i < 32; i++) op("R6 stays off low", 1, 0, 8'(i), 8'h00, 1);

    do_reset();
    op("R6 reset re-arms", 1, 0, 8'h00, 8'h00, 1);
    op("R6 ram kept over reset", 1, 0, 8'h90, 8'h00, 1);

    op("R7 hidden trigger", 1, 0, 8'h30, 8'h00, 0);
    op("R7 trigger while hidden disarms", 1, 0, 8'h01, 8'h00, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule